// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block sits behind the conversion core of a two-channel (I and Q) sampled-data converter and owns everything the downstream logic sees. On every rising edge of its channel clock, each channel takes one raw offset-binary code and registers it onto that channel's output bus. A format-select input picks the coding of both buses. Offset binary passes the code unchanged. Two's complement inverts only the most significant bit.

A two-bit mode input can run both channels in phase or run only the I channel. It can also park both channels, or run both channels with the Q word moved onto the falling edge of the Q clock, half a cycle after I. A parked channel keeps driving its last captured code instead of releasing the bus. The mode input may change at any time relative to either clock, so each clock domain resynchronises it through two flops before acting on it.

Each channel also has a data-valid flag. The flag drops while the channel is parked or in reset. It rises once the channel has run for a fixed warm-up count of sample clocks.

Top module: `dual_adc_outstage`

## Requirements
- R1: While reset is asserted, both output buses show the format applied to a zero code, and both valid flags are low.
- R2: With format-select low, a code presented before a rising edge appears unchanged on the running channel's bus just after that edge.
- R3: With format-select high, the output equals the captured code with bit 7 inverted and bits 6..0 unchanged.
- R4: The mode input is {bit1, bit0}. The encodings are: 00 parks both channels; 01 runs I and parks Q; 10 runs both in phase; 11 runs both with Q delayed by half a cycle.
- R5: A parked channel's bus keeps the last code captured before parking, whatever the raw input does.
- R6: The format is applied after the hold, so a parked word follows a later change of format-select at once.
- R7: In mode 10, the Q bus updates on the same rising edge as I.
- R8: In mode 11, the Q bus updates on the falling edge of the Q clock. Just after a rising edge it still shows the previous sample.
- R9: After reset is released, or after a mode change that un-parks a channel, the channel's valid flag is low through the 21st rising edge and high after the 22nd. This is 2 synchroniser edges plus 20 warm-up counts.
- R10: Once a mode that parks a channel has been applied for three rising edges, that channel's valid flag is low. It stays low while the channel remains parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i_smp | input | 1 | I-channel sample clock |
| clk_q_smp | input | 1 | Q-channel sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_twos | input | 1 | Output format select: 0 offset binary, 1 two's complement |
| mode_sel | input | 2 | Operating mode, asynchronous to both clocks |
| i_raw | input | 8 | Raw offset-binary code, I channel |
| q_raw | input | 8 | Raw offset-binary code, Q channel |
| i_word | output | 8 | I output bus |
| q_word | output | 8 | Q output bus |
| i_valid | output | 1 | I data valid after warm-up |
| q_valid | output | 1 | Q data valid after warm-up |

## Verification
A running channel's bus is due one rising edge after its raw code is driven. In the delayed mode, the Q bus trails by one more falling edge, so just after a rising edge it still shows the previous code. Format changes reach the bus combinationally. A mode change takes effect on the third rising edge. A valid flag rises on the 22nd rising edge after leaving standby or reset.

The bench drives inputs 2 ns after each rising edge and samples right after the next rising edge, before the falling edge. After each mode change it holds the raw codes steady for four edges, so the frozen word is known. Warm-up is checked on both sides of its edge: low after the 21st edge and high after the 22nd.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

    localparam int unsigned CODE_W    = 8;
    localparam int unsigned WARM_CNT  = 20;
    localparam int unsigned SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        MODE_PARK_ALL = 2'b00,
        MODE_I_ONLY   = 2'b01,
        MODE_IQ_SAME  = 2'b10,
        MODE_IQ_LATE  = 2'b11
    } op_mode_e;

    function automatic logic [CODE_W-1:0] fmt_code(input logic twos,
                                                   input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] flip;
        flip = '0;
        flip[CODE_W-1] = twos;
        return code ^ flip;
    endfunction

endpackage

// File: rtl/aoc_mode_sync.sv
module aoc_mode_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_in;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/aoc_channel.sv
module aoc_channel
    import adc_out_pkg::*;
#(
    parameter int unsigned DATA_W  = CODE_W,
    parameter int unsigned WARM    = WARM_CNT,
    localparam int unsigned CNT_W  = $clog2(WARM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_twos,
    input  logic              park,
    input  logic              late_sel,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] word,
    output logic              valid
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
    } ch_state_t;

    localparam logic [CNT_W-1:0] WARM_V = CNT_W'(WARM);

    ch_state_t st_d, st_q;
    logic [DATA_W-1:0] rise_word;
    logic [DATA_W-1:0] late_d, late_q;

    always_comb begin
        st_d = st_q;
        if (park) begin
            st_d.cnt = '0;
        end else begin
            st_d.hold = raw;
            if (st_q.cnt != WARM_V) st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.valid = (st_d.cnt == WARM_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Format after the hold register: a parked word still follows fmt_twos.
    always_comb begin
        rise_word = DATA_W'(fmt_code(fmt_twos, CODE_W'(st_q.hold)));
        late_d    = rise_word;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) late_q <= '0;
        else        late_q <= late_d;
    end

    assign word  = late_sel ? late_q : rise_word;
    assign valid = st_q.valid;

endmodule

// File: rtl/dual_adc_outstage.sv
module dual_adc_outstage
    import adc_out_pkg::*;
#(
    parameter int unsigned DATA_W = CODE_W,
    parameter int unsigned WARM   = WARM_CNT,
    parameter int unsigned SYNC_N = SYNC_LEN
) (
    input  logic              clk_i_smp,
    input  logic              clk_q_smp,
    input  logic              rst_n,
    input  logic              fmt_twos,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] i_raw,
    input  logic [DATA_W-1:0] q_raw,
    output logic [DATA_W-1:0] i_word,
    output logic [DATA_W-1:0] q_word,
    output logic              i_valid,
    output logic              q_valid
);

    logic [1:0] i_mode_s, q_mode_s;
    logic       i_park, q_park, q_late;

    aoc_mode_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync_i (
        .clk(clk_i_smp), .rst_n(rst_n), .async_in(mode_sel), .sync_out(i_mode_s)
    );

    aoc_mode_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync_q (
        .clk(clk_q_smp), .rst_n(rst_n), .async_in(mode_sel), .sync_out(q_mode_s)
    );

    always_comb begin
        i_park = (op_mode_e'(i_mode_s) == MODE_PARK_ALL);
        q_park = (op_mode_e'(q_mode_s) == MODE_PARK_ALL) ||
                 (op_mode_e'(q_mode_s) == MODE_I_ONLY);
        q_late = (op_mode_e'(q_mode_s) == MODE_IQ_LATE);
    end

    aoc_channel #(.DATA_W(DATA_W), .WARM(WARM)) u_ch_i (
        .clk(clk_i_smp), .rst_n(rst_n), .fmt_twos(fmt_twos), .park(i_park),
        .late_sel(1'b0), .raw(i_raw), .word(i_word), .valid(i_valid)
    );

    aoc_channel #(.DATA_W(DATA_W), .WARM(WARM)) u_ch_q (
        .clk(clk_q_smp), .rst_n(rst_n), .fmt_twos(fmt_twos), .park(q_park),
        .late_sel(q_late), .raw(q_raw), .word(q_word), .valid(q_valid)
    );

endmodule

// File: rtl/aoc_checker.sv
module aoc_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              clk_q,
    input logic              rst_n,
    input logic              fmt_twos,
    input logic [1:0]        mode_sel,
    input logic [DATA_W-1:0] i_word,
    input logic              i_valid,
    input logic              q_valid
);

    // R5: I bus frozen while mode 00 has been applied long enough and format is steady
    a_r5_i_park_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mode_sel == 2'b00 && $past(mode_sel, 1) == 2'b00 && $past(mode_sel, 2) == 2'b00 &&
         $past(mode_sel, 3) == 2'b00 && $past(mode_sel, 4) == 2'b00 && $stable(fmt_twos))
        |-> $stable(i_word));

    // R10: I valid cleared after three edges of mode 00
    a_r10_i_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mode_sel == 2'b00 && $past(mode_sel, 1) == 2'b00 && $past(mode_sel, 2) == 2'b00 &&
         $past(mode_sel, 3) == 2'b00) |-> !i_valid);

    // R10: Q valid cleared after three edges of a Q-parking mode
    a_r10_q_valid_drop: assert property (@(posedge clk_q) disable iff (!rst_n)
        (!mode_sel[1] && !$past(mode_sel[1], 1) && !$past(mode_sel[1], 2) &&
         !$past(mode_sel[1], 3)) |-> !q_valid);

    // R9: once valid, I stays valid while its channel keeps running
    a_r9_i_valid_keep: assert property (@(posedge clk_i) disable iff (!rst_n)
        (i_valid && mode_sel != 2'b00 && $past(mode_sel, 1) != 2'b00 &&
         $past(mode_sel, 2) != 2'b00) |=> i_valid);

endmodule

bind dual_adc_outstage aoc_checker #(.DATA_W(DATA_W)) u_aoc_chk (
    .clk_i(clk_i_smp), .clk_q(clk_q_smp), .rst_n(rst_n), .fmt_twos(fmt_twos),
    .mode_sel(mode_sel), .i_word(i_word), .i_valid(i_valid), .q_valid(q_valid)
);

// File: tb/dual_adc_outstage_bench.sv
module dual_adc_outstage_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_twos = 1'b0;
    logic [1:0]    mode_sel = 2'b10;
    logic [DW-1:0] i_raw = '0;
    logic [DW-1:0] q_raw = '0;
    logic [DW-1:0] i_word, q_word;
    logic          i_valid, q_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_adc_outstage u_dual_adc_outstage (
        .clk_i_smp(clk), .clk_q_smp(clk), .rst_n(rst_n), .fmt_twos(fmt_twos),
        .mode_sel(mode_sel), .i_raw(i_raw), .q_raw(q_raw), .i_word(i_word),
        .q_word(q_word), .i_valid(i_valid), .q_valid(q_valid)
    );

    function automatic logic [DW-1:0] exp_fmt(input logic twos, input logic [DW-1:0] c);
        return twos ? {~c[DW-1], c[DW-2:0]} : c;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] ri, rq, rq_prev, q_frz, i_frz;
        int unsigned seed_tap;
        seed_tap = $urandom(32'd5640);

        // R1: reset state
        #(CLK_PERIOD * 3 + 2);
        check("R1 i_word", i_word, 8'h00);
        check("R1 q_word", q_word, 8'h00);
        check("R1 i_valid", {7'd0, i_valid}, 8'd0);
        check("R1 q_valid", {7'd0, q_valid}, 8'd0);
        fmt_twos = 1'b1;
        #1;
        check("R1 fmt during reset", i_word, 8'h80);
        fmt_twos = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R9: warm-up after reset, edge 21 low, edge 22 high
        for (int k = 0; k < 21; k++) step();
        check("R9 reset warmup edge21 i", {7'd0, i_valid}, 8'd0);
        check("R9 reset warmup edge21 q", {7'd0, q_valid}, 8'd0);
        step();
        check("R9 reset warmup edge22 i", {7'd0, i_valid}, 8'd1);
        check("R9 reset warmup edge22 q", {7'd0, q_valid}, 8'd1);

        // R2/R3/R7: in-phase random
        ri = '0; rq = '0;
        for (int k = 0; k < 60; k++) begin
            ri = DW'($urandom); rq = DW'($urandom);
            i_raw = ri; q_raw = rq;
            fmt_twos = (k < 5) ? 1'b0 : (k < 10) ? 1'b1 : 1'($urandom);
            step();
            check(fmt_twos ? "R3 i format" : "R2 i format", i_word, exp_fmt(fmt_twos, ri));
            check("R7 q in phase", q_word, exp_fmt(fmt_twos, rq));
        end
        // directed corner codes
        i_raw = 8'h80; q_raw = 8'h7F; fmt_twos = 1'b1;
        step();
        check("R3 mid code", i_word, 8'h00);
        check("R3 below mid", q_word, 8'hFF);

        // R8: delayed Q
        mode_sel = 2'b11;
        for (int k = 0; k < 4; k++) step();
        rq = q_raw; ri = i_raw;
        for (int k = 0; k < 60; k++) begin
            rq_prev = rq;
            ri = DW'($urandom); rq = DW'($urandom);
            i_raw = ri; q_raw = rq;
            fmt_twos = 1'($urandom);
            step();
            check("R8 i unaffected", i_word, exp_fmt(fmt_twos, ri));
            check("R8 q half cycle late", q_word, exp_fmt(fmt_twos, rq_prev));
        end
        check("R8 q valid kept", {7'd0, q_valid}, 8'd1);

        // R4/R5/R6/R10: mode 01 parks Q
        mode_sel = 2'b01;
        for (int k = 0; k < 4; k++) step();
        q_frz = q_raw;
        check("R10 q valid low", {7'd0, q_valid}, 8'd0);
        check("R4 i still valid", {7'd0, i_valid}, 8'd1);
        for (int k = 0; k < 40; k++) begin
            ri = DW'($urandom); i_raw = ri; q_raw = DW'($urandom);
            fmt_twos = 1'($urandom);
            step();
            check("R4 i runs in 01", i_word, exp_fmt(fmt_twos, ri));
            check(fmt_twos ? "R6 q frozen fmt" : "R5 q frozen", q_word, exp_fmt(fmt_twos, q_frz));
        end

        // mode 00 parks both
        mode_sel = 2'b00;
        for (int k = 0; k < 4; k++) step();
        i_frz = i_raw;
        check("R10 i valid low", {7'd0, i_valid}, 8'd0);
        for (int k = 0; k < 30; k++) begin
            i_raw = DW'($urandom); q_raw = DW'($urandom);
            fmt_twos = k[0];
            step();
            check("R5 i frozen", i_word, exp_fmt(fmt_twos, i_frz));
            check("R6 q frozen", q_word, exp_fmt(fmt_twos, q_frz));
            check("R10 i stays low", {7'd0, i_valid}, 8'd0);
        end
        fmt_twos = ~fmt_twos;
        #1;
        check("R6 immediate fmt", i_word, exp_fmt(fmt_twos, i_frz));

        // R9: leave standby to mode 10
        mode_sel = 2'b10;
        for (int k = 0; k < 21; k++) step();
        check("R9 unpark edge21 i", {7'd0, i_valid}, 8'd0);
        check("R9 unpark edge21 q", {7'd0, q_valid}, 8'd0);
        step();
        check("R9 unpark edge22 i", {7'd0, i_valid}, 8'd1);
        check("R9 unpark edge22 q", {7'd0, q_valid}, 8'd1);
        ri = 8'h3C; rq = 8'hC3; i_raw = ri; q_raw = rq;
        step();
        check("R7 resume i", i_word, exp_fmt(fmt_twos, ri));
        check("R7 resume q", q_word, exp_fmt(fmt_twos, rq));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule